// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block adds a memory-mastering path to a selector/data configuration reader. The host places a 16-byte descriptor in memory. It then writes the descriptor's physical address into a 64-bit pointer register. The engine fetches the descriptor one byte at a time over a request/response memory port. If asked, it switches the current item selection. It then either copies a number of item bytes to a target address or advances the item offset without moving data. It ends by writing a 32-bit status word over the descriptor's control field.

The item contents stay outside the engine. The engine holds the current item key and byte offset and presents them on `item_key` and `item_off`. An external store answers combinationally on `item_len` and `item_byte`. Host selector writes go through the same cursor, so a selection made through the DMA path behaves exactly like one made by the host.

The memory request channel is valid/ready. Once `mem_req_valid` is high, the address, direction and write byte stay frozen until `mem_req_ready` is sampled high. Only one request is outstanding at a time. Valid stays low from acceptance until the matching `mem_rsp_valid` pulse, which must come at least one cycle after acceptance. The response path has no back-pressure: the engine takes every response pulse in the cycle it arrives.

Top module: `cfgdma_engine`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `dma_ptr`, `item_key` and `item_off` are all zero.
- R2: A 32-bit pointer write with `host_wr_low`=0 (the half at offset 0) loads bits 63:32 from `host_wr_data[31:0]` and starts nothing. A write with `host_wr_low`=1 (offset 4) loads bits 31:0 and starts an operation. A write with `host_wr_wide`=1 loads all 64 bits and starts an operation.
- R3: The descriptor is read as 16 single-byte reads at `dma_ptr`+0 through +15, in rising order. Its fields are big-endian: control at bytes 0-3, length at bytes 4-7, target address at bytes 8-15.
- R4: With control bit 3 set, the key is taken from control bits 31:16 and the offset becomes 0, before any data step runs.
- R5: With control bit 1 set, the engine makes `length` byte writes to target+0 onward, in rising order. Each write carries the item byte at the current offset, and the offset rises by one for each accepted write.
- R6: Copy bytes whose offset is at or beyond `item_len` are written as 0x00.
- R7: With control bit 2 set and bit 1 clear, the offset rises by `length` and no data write is issued. With both bits set, the copy is performed.
- R8: Completion is four byte writes at `dma_ptr`+0..3. All four bytes are 0x00 on success. On failure the byte at +3 is 0x01 (control bit 0).
- R9: A response with `mem_rsp_err` during fetch or copy ends the operation, which goes straight to a failure status. Any of control bits 15:4 set gives a failure status with no selection change and no transfer.
- R10: `dma_ptr` reads zero once `busy` falls at the end of an operation.
- R11: While `busy` is high, pointer writes and host selector writes have no effect.
- R12: `host_rd_data` always returns 0x51454D5520434647.
- R13: A request, once valid, holds its address, direction and data until accepted. No request is raised while idle, and at most one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_valid | input | 1 | Pointer register write strobe |
| host_wr_wide | input | 1 | 1: write all 64 bits at once |
| host_wr_low | input | 1 | For 32-bit writes: 1 = low half (offset 4), 0 = high half (offset 0) |
| host_wr_data | input | ADDR_W | Write value; 32-bit writes use bits 31:0 |
| host_rd_data | output | 64 | Pointer register read value (signature) |
| host_sel_valid | input | 1 | Host selector write strobe |
| host_sel_key | input | KEY_W | Host selector key |
| item_key | output | KEY_W | Current item key |
| item_off | output | OFF_W | Current item byte offset |
| item_len | input | OFF_W | Length of the current item |
| item_byte | input | 8 | Item byte at `item_off` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Response pulse |
| mem_rsp_data | input | 8 | Read byte |
| mem_rsp_err | input | 1 | Access failed |
| busy | output | 1 | Operation in progress |
| dma_ptr | output | ADDR_W | Current pointer register contents |

## Verification
Most internal faults show up on the memory port within a request or two. A wrong fetch index or wrong byte order in descriptor assembly sends the copy to the wrong target address or the status to the wrong place. A wrong cursor shows as wrong write bytes on the very next accepted copy write. A fault in the skip arithmetic or offset tracking can stay hidden until a later descriptor reads without selecting, so back-to-back operations that continue from the last offset are needed. A broken busy gate or pointer clear shows as extra, unexpected requests after completion, or a nonzero `dma_ptr` the cycle after `busy` falls.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  localparam logic [63:0] CFGDMA_SIGNATURE = 64'h51454D5520434647;
  localparam int DESC_BYTES   = 16;
  localparam int STATUS_BYTES = 4;
  localparam int CNT_W        = 32;

  // control word bit positions
  localparam int CB_ERR  = 0;
  localparam int CB_READ = 1;
  localparam int CB_SKIP = 2;
  localparam int CB_SEL  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_COPY,
    ST_STATUS
  } eng_st_e;
endpackage

// File: rtl/cfgdma_ptr_reg.sv
module cfgdma_ptr_reg #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic              wr_low,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              clr,
  output logic [ADDR_W-1:0] ptr,
  output logic              start
);
  localparam int HALF = ADDR_W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (wr_en) begin
      if (wr_wide)     ptr                 <= wdata;
      else if (wr_low) ptr[HALF-1:0]       <= wdata[HALF-1:0];
      else             ptr[ADDR_W-1:HALF]  <= wdata[HALF-1:0];
    end
  end

  assign start = wr_en && (wr_wide || wr_low);
endmodule

// File: rtl/cfgdma_cursor.sv
module cfgdma_cursor #(
  parameter int KEY_W = 16,
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [KEY_W-1:0] set_key,
  input  logic             adv_en,
  input  logic [OFF_W-1:0] adv_amt,
  output logic [KEY_W-1:0] key,
  output logic [OFF_W-1:0] off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key <= '0;
      off <= '0;
    end else if (set_en) begin
      key <= set_key;
      off <= '0;
    end else if (adv_en) begin
      off <= off + adv_amt;
    end
  end
endmodule

// File: rtl/cfgdma_desc_sreg.sv
module cfgdma_desc_sreg #(
  parameter int NBYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [7:0]          din,
  output logic [NBYTES*8-1:0] dout
);
  localparam int W = NBYTES * 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout <= '0;
    else if (shift_en) dout <= {dout[W-9:0], din};
  end
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int KEY_W  = 16,
  parameter int OFF_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_valid,
  input  logic              host_wr_wide,
  input  logic              host_wr_low,
  input  logic [ADDR_W-1:0] host_wr_data,
  output logic [63:0]       host_rd_data,
  input  logic              host_sel_valid,
  input  logic [KEY_W-1:0]  host_sel_key,
  output logic [KEY_W-1:0]  item_key,
  output logic [OFF_W-1:0]  item_off,
  input  logic [OFF_W-1:0]  item_len,
  input  logic [7:0]        item_byte,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              busy,
  output logic [ADDR_W-1:0] dma_ptr
);
  localparam int DESC_W = DESC_BYTES * 8;

  eng_st_e            st;
  logic [CNT_W-1:0]   idx;
  logic               pend;
  logic               err;
  logic               trig;
  logic               ptr_clr;
  logic [DESC_W-1:0]  desc;
  logic [31:0]        ctrl;
  logic [31:0]        len;
  logic [ADDR_W-1:0]  tgt;
  logic               bad_ctrl;
  logic               do_read;
  logic               rsp_take;
  logic               req_acc;
  logic               sel_en;
  logic [KEY_W-1:0]   sel_key;
  logic               adv_en;
  logic [OFF_W-1:0]   adv_amt;
  logic               in_range;
  logic               unused_ctrl_err;

  assign host_rd_data = CFGDMA_SIGNATURE;
  assign busy         = (st != ST_IDLE);

  // descriptor fields, big-endian in memory
  assign ctrl     = desc[DESC_W-1 -: 32];
  assign len      = desc[DESC_W-33 -: 32];
  assign tgt      = desc[ADDR_W-1:0];
  assign bad_ctrl = (ctrl[15:4] != '0);
  assign do_read  = ctrl[CB_READ];
  assign unused_ctrl_err = ctrl[CB_ERR];

  assign rsp_take = pend && mem_rsp_valid;
  assign req_acc  = mem_req_valid && mem_req_ready;
  assign in_range = (item_off < item_len);

  cfgdma_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr_valid && !busy),
    .wr_wide (host_wr_wide),
    .wr_low  (host_wr_low),
    .wdata   (host_wr_data),
    .clr     (ptr_clr),
    .ptr     (dma_ptr),
    .start   (trig)
  );

  cfgdma_desc_sreg #(.NBYTES(DESC_BYTES)) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (st == ST_FETCH && rsp_take && !mem_rsp_err),
    .din      (mem_rsp_data),
    .dout     (desc)
  );

  always_comb begin
    sel_en  = 1'b0;
    sel_key = host_sel_key;
    if (st == ST_DECODE) begin
      sel_en  = !bad_ctrl && ctrl[CB_SEL];
      sel_key = ctrl[16 +: KEY_W];
    end else if (!busy) begin
      sel_en  = host_sel_valid;
    end
  end

  always_comb begin
    adv_en  = 1'b0;
    adv_amt = OFF_W'(1);
    if (st == ST_EXEC) begin
      adv_en  = !do_read && ctrl[CB_SKIP];
      adv_amt = OFF_W'(len);
    end else if (st == ST_COPY) begin
      adv_en  = req_acc;
    end
  end

  cfgdma_cursor #(.KEY_W(KEY_W), .OFF_W(OFF_W)) u_cur (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (sel_en),
    .set_key (sel_key),
    .adv_en  (adv_en),
    .adv_amt (adv_amt),
    .key     (item_key),
    .off     (item_off)
  );

  // request channel
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = dma_ptr + ADDR_W'(idx);
    mem_req_wdata = 8'h00;
    case (st)
      ST_FETCH:  mem_req_valid = !pend;
      ST_COPY: begin
        mem_req_valid = !pend;
        mem_req_write = 1'b1;
        mem_req_addr  = tgt + ADDR_W'(idx);
        mem_req_wdata = in_range ? item_byte : 8'h00;
      end
      ST_STATUS: begin
        mem_req_valid = !pend;
        mem_req_write = 1'b1;
        mem_req_wdata = (idx == CNT_W'(STATUS_BYTES-1)) ? {7'd0, err} : 8'h00;
      end
      default: ;
    endcase
  end

  assign ptr_clr = (st == ST_STATUS) && rsp_take && (idx == CNT_W'(STATUS_BYTES-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      idx  <= '0;
      pend <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (req_acc) pend <= 1'b1;
      case (st)
        ST_IDLE: begin
          err  <= 1'b0;
          idx  <= '0;
          pend <= 1'b0;
          if (trig) st <= ST_FETCH;
        end
        ST_FETCH: if (rsp_take) begin
          pend <= 1'b0;
          if (mem_rsp_err) begin
            err <= 1'b1;
            idx <= '0;
            st  <= ST_STATUS;
          end else if (idx == CNT_W'(DESC_BYTES-1)) begin
            idx <= '0;
            st  <= ST_DECODE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DECODE: begin
          if (bad_ctrl) begin
            err <= 1'b1;
            st  <= ST_STATUS;
          end else begin
            st  <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          idx <= '0;
          st  <= (do_read && len != '0) ? ST_COPY : ST_STATUS;
        end
        ST_COPY: if (rsp_take) begin
          pend <= 1'b0;
          if (mem_rsp_err) begin
            err <= 1'b1;
            idx <= '0;
            st  <= ST_STATUS;
          end else if (idx == len - 1'b1) begin
            idx <= '0;
            st  <= ST_STATUS;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_STATUS: if (rsp_take) begin
          pend <= 1'b0;
          if (idx == CNT_W'(STATUS_BYTES-1)) begin
            idx <= '0;
            st  <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgdma_engine_chk.sv
module cfgdma_engine_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [ADDR_W-1:0] dma_ptr,
  input logic              host_wr_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [7:0]        mem_req_wdata
);
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  // R13
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R10
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> dma_ptr == '0);

  // R11
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && host_wr_valid |=> ($stable(dma_ptr) || dma_ptr == '0));
endmodule

bind cfgdma_engine cfgdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .dma_ptr       (dma_ptr),
  .host_wr_valid (host_wr_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/sim_cfgdma_engine.sv
`timescale 1ns/1ps
module sim_cfgdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_valid = 1'b0, host_wr_wide = 1'b0, host_wr_low = 1'b0;
  logic [63:0] host_wr_data = '0;
  logic [63:0] host_rd_data;
  logic        host_sel_valid = 1'b0;
  logic [15:0] host_sel_key = '0;
  logic [15:0] item_key;
  logic [31:0] item_off, item_len;
  logic [7:0]  item_byte;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [63:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        busy;
  logic [63:0] dma_ptr;

  always #2 clk = ~clk;

  cfgdma_engine u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem [0:255];
  logic [15:0] mdl_key = '0;
  logic [31:0] mdl_off = '0;
  int err_target = -1, req_n = 0;
  logic exp_wr[$];
  logic [63:0] exp_addr[$];
  logic [7:0] exp_data[$];
  string exp_tag[$];

  function automatic logic [31:0] ilen(logic [15:0] k);
    return 32'(k[3:0]) + 32'd3;
  endfunction
  function automatic logic [7:0] ibyte(logic [15:0] k, logic [31:0] o);
    return k[7:0] ^ (o[7:0] * 8'd5) ^ 8'hA5;
  endfunction

  assign item_len  = ilen(item_key);
  assign item_byte = ibyte(item_key, item_off);

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic w, logic [63:0] a, logic [7:0] d, string tag);
    exp_wr.push_back(w); exp_addr.push_back(a);
    exp_data.push_back(d); exp_tag.push_back(tag);
  endtask

  // memory responder and scoreboard monitor
  logic acc_pend = 1'b0, acc_err = 1'b0;
  logic [7:0] acc_rdata = '0;
  logic [7:0] lfsr = 8'h5B;
  always @(negedge clk) begin
    if (rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (acc_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = acc_rdata;
        mem_rsp_err   = acc_err;
        acc_pend = 1'b0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = lfsr[0] | lfsr[1];
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr.size() == 0) begin
          chk(0, "R13 unexpected request", mem_req_addr, 64'hx);
        end else begin
          logic w; logic [63:0] a; logic [7:0] d; string t;
          w = exp_wr.pop_front(); a = exp_addr.pop_front();
          d = exp_data.pop_front(); t = exp_tag.pop_front();
          chk(mem_req_write == w, {t, " dir"}, 64'(mem_req_write), 64'(w));
          chk(mem_req_addr == a, {t, " addr"}, mem_req_addr, a);
          if (w) chk(mem_req_wdata == d, {t, " data"}, 64'(mem_req_wdata), 64'(d));
        end
        acc_err   = (req_n == err_target);
        acc_rdata = mem[mem_req_addr[7:0]];
        if (mem_req_write) mem[mem_req_addr[7:0]] = mem_req_wdata;
        req_n++;
        acc_pend = 1'b1;
      end
    end
  end

  task automatic do_op(logic [63:0] p, logic [31:0] ctrl, logic [31:0] len,
                       logic [63:0] tgt, int err_at, bit split, bit poke);
    logic [127:0] d;
    int n;
    bit e;
    d = {ctrl, len, tgt};
    for (int i = 0; i < 16; i++) mem[8'(p[7:0] + 8'(i))] = d[127-8*i -: 8];
    n = 0; e = 0;
    for (int i = 0; i < 16 && !e; i++) begin
      push(0, p + 64'(i), 8'h00, "R3 fetch");
      if (n == err_at) e = 1;
      n++;
    end
    if (!e && ctrl[15:4] != 0) e = 1;
    else if (!e) begin
      if (ctrl[3]) begin mdl_key = ctrl[31:16]; mdl_off = 0; end
      if (ctrl[1]) begin
        for (int unsigned i = 0; i < len && !e; i++) begin
          push(1, tgt + 64'(i), (mdl_off < ilen(mdl_key)) ? ibyte(mdl_key, mdl_off) : 8'h00,
               "R5 R6 copy");
          mdl_off++;
          if (n == err_at) e = 1;
          n++;
        end
      end else if (ctrl[2]) mdl_off += len;
    end
    for (int i = 0; i < 4; i++)
      push(1, p + 64'(i), (i == 3) ? {7'd0, e} : 8'h00, "R8 R9 status");
    err_target = err_at; req_n = 0;
    @(negedge clk);
    host_wr_valid = 1;
    if (split) begin
      host_wr_wide = 0; host_wr_low = 0; host_wr_data = {32'd0, p[63:32]};
      @(negedge clk);
      chk(dma_ptr[63:32] == p[63:32] && !busy, "R2 high half load", dma_ptr, p);
      host_wr_low = 1; host_wr_data = {32'd0, p[31:0]};
    end else begin
      host_wr_wide = 1; host_wr_data = p;
    end
    @(negedge clk);
    host_wr_valid = 0; host_wr_wide = 0; host_wr_low = 0;
    chk(busy == 1'b1, "R2 start", 64'(busy), 64'd1);
    for (int c = 0; busy && c < 2000; c++) begin
      if (poke && c == 4) begin
        host_wr_valid = 1; host_wr_low = 1; host_wr_data = 64'h40;
        host_sel_valid = 1; host_sel_key = 16'h0007;
      end else begin
        host_wr_valid = 0; host_wr_low = 0; host_sel_valid = 0;
      end
      @(negedge clk);
    end
    host_wr_valid = 0; host_wr_low = 0; host_sel_valid = 0;
    chk(dma_ptr == 0, "R10 ptr cleared", dma_ptr, 0);
    chk(item_key == mdl_key, "R4 R11 key", 64'(item_key), 64'(mdl_key));
    chk(item_off == mdl_off, "R7 offset", 64'(item_off), 64'(mdl_off));
    repeat (6) @(negedge clk);
    chk(exp_addr.size() == 0 && !busy, "R11 R13 all requests seen",
        64'(exp_addr.size()), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid, "R1 idle", {busy, mem_req_valid}, 0);
    chk(dma_ptr == 0 && item_key == 0 && item_off == 0, "R1 state", dma_ptr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rd_data == 64'h51454D5520434647, "R12 signature", host_rd_data,
        64'h51454D5520434647);
    do_op(64'h10, 32'h0005_000A, 32'd6, 64'h80, -1, 0, 0);   // R4 R5
    do_op(64'h30, 32'h0000_0002, 32'd6, 64'h90, -1, 0, 0);   // R6 continue
    do_op(64'h10, 32'h000C_000C, 32'd5, 64'h0, -1, 0, 0);    // R7 skip
    do_op(64'h30, 32'h0000_0006, 32'd4, 64'h2_0000_00A0, -1, 0, 0); // R7 both
    do_op(64'h1_0000_0020, 32'h0003_000A, 32'd3, 64'hB0, -1, 1, 0); // R2 split
    do_op(64'h40, 32'h0009_000A, 32'd4, 64'hC0, 7, 0, 0);    // R9 fetch err
    do_op(64'h40, 32'h0009_000A, 32'd6, 64'hC0, 18, 0, 0);   // R9 copy err
    do_op(64'h50, 32'h000E_001A, 32'd4, 64'hD0, -1, 0, 0);   // R9 bad bits
    do_op(64'h60, 32'h0002_000A, 32'd8, 64'hE0, -1, 0, 1);   // R11 poke
    host_sel_valid = 1; host_sel_key = 16'h0004;
    @(negedge clk);
    host_sel_valid = 0; mdl_key = 16'h0004; mdl_off = 0;
    do_op(64'h70, 32'h0000_0002, 32'd0, 64'hF0, -1, 0, 0);   // zero length
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule